// File: doc/BRIEF.md
# Bit-banged serial EEPROM responder

This block stands in for a small serial EEPROM that a host drives by software. The host never toggles a real serial line. Instead it writes a control word that holds a serial clock bit, a data-in bit and an access-request bit. The block compares each written clock bit with the previous one. On a low-to-high change it consumes one serial bit. Each command starts with an 8-bit opcode. A read command then takes an 8-bit byte address and returns one 16-bit word, one bit per clock edge. A status command returns eight zero bits.

The storage is a fixed table of 64 words of 16 bits each. Words 0 to 2 hold a station address. The last word is a checksum that brings the sum of all words to a known constant. Every other word is zero. The access grant follows the request on every control write. The host sees this as an immediate grant. An error flag records an unsupported opcode or a word index beyond the table. The flag stays set until reset.

Top module: `bbEeprom`

## Requirements
- R1: After reset, doBit, grantBit and errFlag are all 0.
- R2: On every control write (wrEn high), grantBit takes the value of wrReq in the following cycle. Without a write, grantBit holds its value.
- R3: Only a control write whose wrSk is 1 while the previously written wrSk was 0 advances the command sequence. Writes that keep wrSk high, or that bring it low, leave the sequence and doBit unchanged. doBit also holds on cycles without a write.
- R4: The first 8 rising clock writes shift wrDi into the opcode, most significant bit first. The read opcode is 0x03 and the status opcode is 0x05.
- R5: After a read opcode, the next 8 rising writes shift in a byte address, most significant bit first. The next 16 rising writes each present on doBit, one cycle after the write, one bit of word (address >> 1), most significant bit first.
- R6: After a status opcode, each of the next 8 rising writes drives doBit to 0.
- R7: After the 16th data bit of a read, or the 8th bit of a status command, the opcode, address and counters clear. The next rising write starts a new opcode.
- R8: When 8 opcode bits are complete and the opcode is neither 0x03 nor 0x05, errFlag becomes 1 and the sequence returns to the opcode phase. errFlag stays 1 until reset.
- R9: Words 0, 1 and 2 read as 0xA4A4, 0xB6B6 and 0xC8C8. Word 63 reads as 0x9698, so the 16-bit sum of all 64 words is 0xBABA. All other words read as 0.
- R10: A read whose word index (address >> 1) is 64 or more sets errFlag and drives doBit to 0 for each data bit. A read with an index below 64 leaves errFlag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Control-word write strobe |
| wrSk | input | 1 | Serial clock bit of the written control word |
| wrDi | input | 1 | Serial data-in bit of the written control word |
| wrReq | input | 1 | Access request bit of the written control word |
| doBit | output | 1 | Serial data-out bit |
| grantBit | output | 1 | Access grant, follows the last written request |
| errFlag | output | 1 | Sticky error: unsupported opcode or index out of range |

## Verification
The checker watches several properties on every cycle. The grant must track each write and hold between writes. doBit must not move without a write. A status bit and an out-of-range read must both drive doBit low. The error flag must never clear by itself, and the sequencer must issue at most one action per edge. Other behaviour shows only in the bench's scenarios: the table contents, the checksum total, and opcode bit order. So do the rule that writes without an edge are ignored, and the restart after a completed or rejected command. Each of these needs a whole serial transaction before the result can be compared.

// File: rtl/bbEepromPkg.sv
package bbEepromPkg;

  localparam int WORD_W     = 16;
  localparam int WORD_COUNT = 64;
  localparam int ADDR_W     = 8;
  localparam int OP_W       = 8;
  localparam int STATUS_W   = 8;
  localparam int SEL_W      = $clog2(WORD_W);

  localparam logic [OP_W-1:0]   OP_READ     = 8'h03;
  localparam logic [OP_W-1:0]   OP_STATUS   = 8'h05;
  localparam logic [WORD_W-1:0] SUM_TARGET  = 16'hBABA;

  typedef enum logic [1:0] {
    PH_OP   = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } seqPhase_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic             addrShift;
    logic             addrClear;
    logic             bitLoad;
    logic             bitZero;
    logic             shiftIn;
    logic [SEL_W-1:0] bitSel;
  } seqStrobe_t;

  function automatic logic [WORD_W-1:0] seedWord(input int idx);
    case (idx)
      0:       return 16'hA4A4;
      1:       return 16'hB6B6;
      2:       return 16'hC8C8;
      default: return '0;
    endcase
  endfunction

  // last word balances the sum of the table to SUM_TARGET
  function automatic logic [WORD_W-1:0] romWord(input int idx);
    logic [WORD_W-1:0] acc;
    acc = '0;
    if (idx != WORD_COUNT - 1) return seedWord(idx);
    for (int i = 0; i < WORD_COUNT - 1; i++) acc = acc + seedWord(i);
    return SUM_TARGET - acc;
  endfunction

endpackage

// File: rtl/bbEepromData.sv
module bbEepromData
  import bbEepromPkg::*;
#(
  parameter int WORDS  = WORD_COUNT,
  parameter int WIDTH  = WORD_W,
  parameter int AWIDTH = ADDR_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  output logic       doBit,
  output logic       idxOver
);

  localparam int IDX_W = $clog2(WORDS);
  localparam logic [SEL_W-1:0] TOP_BIT = SEL_W'(WIDTH - 1);

  logic [AWIDTH-1:0] addrReg;
  logic [WIDTH-1:0]  romTable [WORDS];
  logic [WIDTH-1:0]  curWord;

  for (genvar g = 0; g < WORDS; g++) begin : g_rom
    assign romTable[g] = romWord(g);
  end

  always_comb begin
    idxOver = (int'(addrReg[AWIDTH-1:1]) >= WORDS);
    curWord = idxOver ? '0 : romTable[addrReg[IDX_W:1]];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      doBit   <= 1'b0;
    end else begin
      if (strb.addrClear)
        addrReg <= '0;
      else if (strb.addrShift)
        addrReg <= {addrReg[AWIDTH-2:0], strb.shiftIn};

      if (strb.bitLoad)
        doBit <= curWord[TOP_BIT - strb.bitSel];
      else if (strb.bitZero)
        doBit <= 1'b0;
    end
  end

endmodule

// File: rtl/bbEepromCtrl.sv
module bbEepromCtrl
  import bbEepromPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrSk,
  input  logic       wrDi,
  input  logic       wrReq,
  input  logic       idxOver,
  output seqStrobe_t strb,
  output logic       grantBit,
  output logic       errFlag
);

  logic             skPrev;
  logic             skRise;
  seqPhase_t        phase;
  logic [SEL_W-1:0] bitCnt;
  logic [OP_W-1:0]  opcode;
  logic [OP_W-1:0]  nextOp;
  logic             isRead;
  logic             lastOpBit;
  logic             lastAddrBit;
  logic             lastDataBit;

  always_comb begin
    skRise      = wrEn && wrSk && !skPrev;
    isRead      = (opcode == OP_READ);
    nextOp      = {opcode[OP_W-2:0], wrDi};
    lastOpBit   = (bitCnt == SEL_W'(OP_W - 1));
    lastAddrBit = (bitCnt == SEL_W'(ADDR_W - 1));
    lastDataBit = isRead ? (bitCnt == SEL_W'(WORD_W - 1))
                         : (bitCnt == SEL_W'(STATUS_W - 1));
  end

  always_comb begin
    strb         = '0;
    strb.shiftIn = wrDi;
    strb.bitSel  = bitCnt;
    if (skRise) begin
      case (phase)
        PH_ADDR: strb.addrShift = 1'b1;
        PH_DATA: begin
          strb.bitLoad   = isRead;
          strb.bitZero   = !isRead;
          strb.addrClear = lastDataBit;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      skPrev   <= 1'b0;
      grantBit <= 1'b0;
      errFlag  <= 1'b0;
      phase    <= PH_OP;
      bitCnt   <= '0;
      opcode   <= '0;
    end else begin
      if (wrEn) begin
        skPrev   <= wrSk;
        grantBit <= wrReq;
      end
      if (skRise) begin
        case (phase)
          PH_OP: begin
            opcode <= nextOp;
            if (lastOpBit) begin
              bitCnt <= '0;
              if (nextOp == OP_READ)
                phase <= PH_ADDR;
              else if (nextOp == OP_STATUS)
                phase <= PH_DATA;
              else begin
                errFlag <= 1'b1;
                opcode  <= '0;
              end
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          PH_ADDR: begin
            if (lastAddrBit) begin
              bitCnt <= '0;
              phase  <= PH_DATA;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          PH_DATA: begin
            if (isRead && idxOver) errFlag <= 1'b1;
            if (lastDataBit) begin
              bitCnt <= '0;
              opcode <= '0;
              phase  <= PH_OP;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          default: begin
            bitCnt <= '0;
            phase  <= PH_OP;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/bbEeprom.sv
module bbEeprom
  import bbEepromPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic wrSk,
  input  logic wrDi,
  input  logic wrReq,
  output logic doBit,
  output logic grantBit,
  output logic errFlag
);

  seqStrobe_t strb;
  logic       idxOver;

  bbEepromCtrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSk     (wrSk),
    .wrDi     (wrDi),
    .wrReq    (wrReq),
    .idxOver  (idxOver),
    .strb     (strb),
    .grantBit (grantBit),
    .errFlag  (errFlag)
  );

  bbEepromData #(
    .WORDS  (WORD_COUNT),
    .WIDTH  (WORD_W),
    .AWIDTH (ADDR_W)
  ) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .doBit   (doBit),
    .idxOver (idxOver)
  );

endmodule

// File: rtl/bbEepromChecker.sv
module bbEepromChecker
  import bbEepromPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       wrReq,
  input logic       doBit,
  input logic       grantBit,
  input logic       errFlag,
  input seqStrobe_t strb,
  input logic       idxOver
);

  a_r2_grant_tracks: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (grantBit == $past(wrReq)));

  a_r2_grant_holds: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(grantBit));

  a_r3_do_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(doBit));

  a_r5_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.addrShift, strb.bitLoad, strb.bitZero}));

  a_r6_status_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.bitZero |=> !doBit);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  a_r10_range_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bitLoad && idxOver) |=> (!doBit && errFlag));

endmodule

bind bbEeprom bbEepromChecker i_chk (.*);

// File: tb/test_bbEeprom.sv
module test_bbEeprom;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 7;
  // {byte address, expected word}
  localparam logic [23:0] VEC [N_VEC] = '{
    {8'h00, 16'hA4A4},
    {8'h02, 16'hB6B6},
    {8'h05, 16'hC8C8},
    {8'h7E, 16'h9698},
    {8'h7F, 16'h9698},
    {8'h0A, 16'h0000},
    {8'h40, 16'h0000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, wrSk = 1'b0, wrDi = 1'b0, wrReq = 1'b0;
  logic doBit, grantBit, errFlag;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bbEeprom i_bbEeprom (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSk(wrSk), .wrDi(wrDi),
    .wrReq(wrReq), .doBit(doBit), .grantBit(grantBit), .errFlag(errFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    wrEn = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic sk, input logic di, input logic req);
    @(negedge clk);
    wrEn = 1'b1; wrSk = sk; wrDi = di; wrReq = req;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic clockBit(input logic di, output logic seen);
    hostWrite(1'b0, di, 1'b1);
    hostWrite(1'b1, di, 1'b1);
    seen = doBit;
  endtask

  task automatic sendByte(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
  endtask

  task automatic readWord(input logic [7:0] addr, output logic [15:0] w);
    logic s;
    sendByte(8'h03);
    sendByte(addr);
    w = '0;
    for (int i = 0; i < 16; i++) begin
      clockBit(1'b0, s);
      w = {w[14:0], s};
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic [15:0] sum;
    logic s;
    logic held;

    doReset();
    check("R1 doBit", {31'd0, doBit}, 32'd0);
    check("R1 grantBit", {31'd0, grantBit}, 32'd0);
    check("R1 errFlag", {31'd0, errFlag}, 32'd0);

    // table of reads
    for (int v = 0; v < N_VEC; v++) begin
      readWord(VEC[v][23:16], w);
      check("R5 R9 word", {16'd0, w}, {16'd0, VEC[v][15:0]});
      check("R10 in range no error", {31'd0, errFlag}, 32'd0);
    end

    // checksum over the whole table
    sum = '0;
    for (int k = 0; k < 64; k++) begin
      readWord(8'(2 * k), w);
      sum = sum + w;
    end
    check("R9 sum", {16'd0, sum}, 32'h0000BABA);

    // grant follows request
    hostWrite(1'b0, 1'b0, 1'b0);
    check("R2 grant low", {31'd0, grantBit}, 32'd0);
    hostWrite(1'b0, 1'b0, 1'b1);
    check("R2 grant high", {31'd0, grantBit}, 32'd1);
    repeat (4) @(negedge clk);
    check("R2 grant holds", {31'd0, grantBit}, 32'd1);

    // writes without a rising edge are ignored
    for (int i = 7; i >= 0; i--) begin
      clockBit(i < 2 ? 1'b1 : 1'b0, s);
      hostWrite(1'b1, 1'b1, 1'b1);
      hostWrite(1'b0, 1'b1, 1'b1);
    end
    sendByte(8'h02);
    w = '0;
    for (int i = 0; i < 16; i++) begin
      clockBit(1'b0, s);
      w = {w[14:0], s};
      held = doBit;
      hostWrite(1'b1, 1'b1, 1'b1);
      hostWrite(1'b1, 1'b0, 1'b1);
      hostWrite(1'b0, 1'b1, 1'b1);
      if (i == 3) check("R3 doBit unchanged", {31'd0, doBit}, {31'd0, held});
    end
    check("R3 word with noise", {16'd0, w}, 32'h0000B6B6);

    // status command then back-to-back read
    sendByte(8'h05);
    for (int i = 0; i < 8; i++) begin
      clockBit(1'b1, s);
      if (s !== 1'b0) check("R6 status bit", {31'd0, s}, 32'd0);
    end
    check("R6 status error free", {31'd0, errFlag}, 32'd0);
    readWord(8'h04, w);
    check("R7 restart after status", {16'd0, w}, 32'h0000C8C8);

    // opcode is MSB first: reversed read code is unsupported
    sendByte(8'hC0);
    check("R4 reversed opcode rejected", {31'd0, errFlag}, 32'd1);
    doReset();
    check("R1 error cleared by reset", {31'd0, errFlag}, 32'd0);

    // unknown opcode
    sendByte(8'h06);
    check("R8 unknown opcode flag", {31'd0, errFlag}, 32'd1);
    readWord(8'h02, w);
    check("R8 sequencer restarted", {16'd0, w}, 32'h0000B6B6);
    check("R8 flag sticky", {31'd0, errFlag}, 32'd1);

    // out-of-range index
    doReset();
    readWord(8'h80, w);
    check("R10 out of range data", {16'd0, w}, 32'd0);
    check("R10 out of range flag", {31'd0, errFlag}, 32'd1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule